// File: doc/BRIEF.md
# Grouped Pin Interrupt Router

This block watches a wide bank of general-purpose input pins and funnels a chosen subset of them into eight interrupt slots. Each slot owns a small selector that names one byte lane of one port; the slot's own number then picks the bit inside that lane. So slot g can only ever watch a pin whose index within its port is congruent to g modulo 8. The chosen pin is synchronised, then judged against the slot's trigger code: level high, level low, rising, falling or either edge. A forced-pending code and an off code are also available.

A pending bit per slot records the result. Edge-triggered slots keep the bit until software writes a one to that slot's position in the acknowledge register. Level-triggered slots track the pin, so acknowledging them is pointless while the level persists. A mask enables slots onto a single combined interrupt line. Software reaches everything through a word-addressed write/read bus with a one-cycle read latency.

Top module: `pin_irq_router`

## Requirements
- R1: After reset the trigger, selector and mask registers read 0, the raw and masked status read 0, and `irq_o` is 0.
- R2: The trigger register (byte address 120, bits 23:0), selector register (address 124, bits 31:0) and mask register (address 128, bits 7:0) return what was last written. Unimplemented bits read 0. Read data appears one clock after the address is presented.
- R3: Slot g watches flat pin index `sel_g*8 + g`, where `sel_g` is bits 4g+3:4g of the selector register. That is port `sel_g[3:2]`, bit `sel_g[1:0]*8 + g` of that port. A pin outside that choice has no effect on slot g.
- R4: The trigger code of slot g is in bits 3g+2:3g. Code 5 latches pending on a rising edge, code 6 on a falling edge and code 7 on either edge. Pending is set on the third rising clock edge after the pin changes.
- R5: Code 1 makes pending equal the synchronised pin level and code 2 its inverse. An acknowledge does not keep it cleared while the level persists.
- R6: Code 3 forces pending to 1. Codes 0 and 4 force pending to 0, which also discards a latched edge.
- R7: Writing address 132 clears the latched pending of every edge slot whose data bit is 1. Bits written as 0 leave their slots unchanged.
- R8: Address 136 reads the raw pending bits in 7:0. Address 140 reads the pending bits ANDed with the mask.
- R9: `irq_o` is the registered OR of the masked pending bits. It rises one clock after a masked pending bit sets and falls one clock after the last one clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 128 | All port pins, port p bit b at index p*32+b |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wen_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A pin change applied just after a falling clock edge passes two synchroniser flops and the pending register, so pending is set on the third rising edge. The combined line follows one edge later. The edge-trigger test checks that exact timing: it samples `irq_o` low after three edges and high after four. A write takes effect at the edge that captures it. Read data is sampled at the falling edge that follows the capturing edge. Status reads after a pin change wait at least four edges, so every pipeline stage has settled before the sample.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RSV  = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_ANY  = 3'd7
  } trig_e;

  localparam int TRIG_W = 3;

  localparam logic [7:0] A_TRIG   = 8'd120;
  localparam logic [7:0] A_SEL    = 8'd124;
  localparam logic [7:0] A_MASK   = 8'd128;
  localparam logic [7:0] A_ACK    = 8'd132;
  localparam logic [7:0] A_RAW    = 8'd136;
  localparam logic [7:0] A_MASKED = 8'd140;

  function automatic logic is_edge(trig_e c);
    return (c == TRIG_RISE) || (c == TRIG_FALL) || (c == TRIG_ANY);
  endfunction
endpackage

// File: rtl/pin_irq_slot.sv
module pin_irq_slot
  import pin_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_i,
  input  trig_e code_i,
  input  logic  ack_i,
  output logic  pend_o
);
  logic s1, s2, s3;
  logic rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb begin
    case (code_i)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
    end else begin
      case (code_i)
        TRIG_HIGH: pend_o <= s2;
        TRIG_LOW:  pend_o <= ~s2;
        TRIG_SET:  pend_o <= 1'b1;
        TRIG_RISE, TRIG_FALL, TRIG_ANY: begin
          if (hit)        pend_o <= 1'b1;
          else if (ack_i) pend_o <= 1'b0;
        end
        default:   pend_o <= 1'b0;
      endcase
    end
  end

  assert_off_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (code_i == TRIG_OFF || code_i == TRIG_RSV) |=> !pend_o);
  assert_set_forces_R6: assert property (@(posedge clk) disable iff (rst)
    (code_i == TRIG_SET) |=> pend_o);
  assert_edge_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (is_edge(code_i) && pend_o && !ack_i) |=> pend_o);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (is_edge(code_i) && ack_i && !rise && !fall) |=> !pend_o);
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NGRP   = 8,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wen_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NGRP-1:0]       pend_i,
  output logic [TRIG_W*NGRP-1:0] trig_o,
  output logic [SEL_W*NGRP-1:0] sel_o,
  output logic [NGRP-1:0]       mask_o,
  output logic [NGRP-1:0]       ack_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int TW = TRIG_W * NGRP;
  localparam int SW = SEL_W * NGRP;

  logic hit_trig, hit_sel, hit_mask, hit_ack;

  assign hit_trig = (addr_i == ADDR_W'(A_TRIG));
  assign hit_sel  = (addr_i == ADDR_W'(A_SEL));
  assign hit_mask = (addr_i == ADDR_W'(A_MASK));
  assign hit_ack  = (addr_i == ADDR_W'(A_ACK));

  assign ack_o = (wen_i && hit_ack) ? wdata_i[NGRP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_o <= '0;
      sel_o  <= '0;
      mask_o <= '0;
    end else if (wen_i) begin
      if (hit_trig) trig_o <= wdata_i[TW-1:0];
      if (hit_sel)  sel_o  <= wdata_i[SW-1:0];
      if (hit_mask) mask_o <= wdata_i[NGRP-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (hit_trig) rdata_o[TW-1:0] <= trig_o;
      if (hit_sel)  rdata_o[SW-1:0] <= sel_o;
      if (hit_mask) rdata_o[NGRP-1:0] <= mask_o;
      if (addr_i == ADDR_W'(A_RAW))    rdata_o[NGRP-1:0] <= pend_i;
      if (addr_i == ADDR_W'(A_MASKED)) rdata_o[NGRP-1:0] <= pend_i & mask_o;
    end
  end

  assert_trig_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wen_i && hit_trig) |=> (trig_o == $past(wdata_i[TW-1:0])));
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wen_i && hit_mask) |=> (mask_o == $past(wdata_i[NGRP-1:0])));
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
  import pin_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int NGRP      = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_wen_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  output logic                        irq_o
);
  localparam int TOTAL = NUM_PORTS * PORT_W;
  localparam int LANES = TOTAL / NGRP;
  localparam int SEL_W = $clog2(LANES);
  localparam int IDX_W = $clog2(TOTAL);

  logic [TRIG_W*NGRP-1:0] trig;
  logic [SEL_W*NGRP-1:0]  sel;
  logic [NGRP-1:0]        mask, ack, pend;

  pin_irq_regs #(
    .NGRP(NGRP), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .addr_i(bus_addr_i), .wen_i(bus_wen_i), .wdata_i(bus_wdata_i),
    .pend_i(pend), .trig_o(trig), .sel_o(sel), .mask_o(mask),
    .ack_o(ack), .rdata_o(bus_rdata_o)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_slot
    logic [IDX_W-1:0] idx;
    logic             pin;
    assign idx = IDX_W'(sel[SEL_W*g +: SEL_W]) * IDX_W'(NGRP) + IDX_W'(g);
    assign pin = pins_i[idx];

    pin_irq_slot slot_i (
      .clk(clk), .rst(rst), .pin_i(pin),
      .code_i(trig_e'(trig[TRIG_W*g +: TRIG_W])),
      .ack_i(ack[g]), .pend_o(pend[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend & mask);
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (|(pend & mask)) |=> irq_o);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & mask)) |=> !irq_o);
endmodule

// File: tb/pin_irq_router_tb.sv
module pin_irq_router_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] pins = '0;
  logic [7:0]   addr = '0;
  logic         wen = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_irq_router dut_i (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_addr_i(addr),
    .bus_wen_i(wen), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    tick(1);
    wen = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; wen = 1'b0;
    tick(1);
    d = rdata;
  endtask

  // switch routing with the slot off, let the synchroniser settle, then arm
  task automatic arm(input logic [31:0] sel, input logic [31:0] trig, input logic [31:0] msk);
    wr(8'd120, 32'h0);
    wr(8'd124, sel);
    tick(4);
    wr(8'd120, trig);
    wr(8'd128, msk);
    tick(1);
    wr(8'd132, 32'hFF);
    tick(1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'd120, d); check("R1 trig", d, 32'h0);
    rd(8'd124, d); check("R1 sel", d, 32'h0);
    rd(8'd128, d); check("R1 mask", d, 32'h0);
    rd(8'd136, d); check("R1 raw", d, 32'h0);
    rd(8'd140, d); check("R1 masked", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'd124, 32'h89ABCDEF); rd(8'd124, d); check("R2 sel", d, 32'h89ABCDEF);
    wr(8'd128, 32'h000001A5); rd(8'd128, d); check("R2 mask", d, 32'h000000A5);
    wr(8'd120, 32'hFF000000 | (32'd6 << 9)); rd(8'd120, d); check("R2 trig", d, 32'd6 << 9);
    wr(8'd120, 32'h0); wr(8'd124, 32'h0); wr(8'd128, 32'h0);
    rd(8'd132, d); check("R2 ack reads 0", d, 32'h0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    // slot 2, selector 6 = port 1 byte 2 -> flat pin 50
    arm(32'd6 << 8, 32'd5 << 6, 32'h04);
    pins[2] = 1'b1; tick(5);
    rd(8'd136, d); check("R3 unselected pin ignored", d, 32'h0);
    pins[50] = 1'b1;
    tick(3); check("R9 irq not yet", {31'b0, irq}, 32'h0);
    tick(1); check("R4 R9 irq after pending", {31'b0, irq}, 32'h1);
    rd(8'd136, d); check("R8 raw rise", d, 32'h04);
    rd(8'd140, d); check("R8 masked rise", d, 32'h04);
    wr(8'd132, 32'h0); tick(2);
    rd(8'd136, d); check("R7 zero ack keeps", d, 32'h04);
    wr(8'd132, 32'hFB); tick(2);
    rd(8'd136, d); check("R7 other bits keep", d, 32'h04);
    wr(8'd128, 32'h0); tick(2);
    check("R9 masked off irq", {31'b0, irq}, 32'h0);
    rd(8'd140, d); check("R8 masked zero", d, 32'h0);
    rd(8'd136, d); check("R8 raw still set", d, 32'h04);
    wr(8'd128, 32'h04);
    wr(8'd132, 32'h04); tick(1);
    check("R9 irq drops after ack", {31'b0, irq}, 32'h0);
    rd(8'd136, d); check("R7 ack clears", d, 32'h0);
    pins[50] = 1'b0; pins[2] = 1'b0; tick(5);
    rd(8'd136, d); check("R4 fall ignored in rise mode", d, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    // slot 5, selector 0 -> pin 5
    arm(32'h0, 32'd6 << 15, 32'h20);
    pins[5] = 1'b1; tick(5);
    rd(8'd136, d); check("R4 rise ignored in fall mode", d, 32'h0);
    pins[5] = 1'b0; tick(5);
    rd(8'd136, d); check("R4 fall latched", d, 32'h20);
    check("R9 irq fall", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_both;
    logic [31:0] d;
    // slot 7, selector 15 -> pin 127 (port 3 bit 31)
    arm(32'hF << 28, 32'd7 << 21, 32'h80);
    pins[127] = 1'b1; tick(5);
    rd(8'd136, d); check("R3 R4 any-edge rise", d, 32'h80);
    wr(8'd132, 32'h80); tick(1);
    rd(8'd136, d); check("R7 ack any-edge", d, 32'h0);
    pins[127] = 1'b0; tick(5);
    rd(8'd136, d); check("R4 any-edge fall", d, 32'h80);
  endtask

  task automatic t_level;
    logic [31:0] d;
    // slot 0, selector 3 -> pin 24
    arm(32'h3, 32'd1, 32'h01);
    rd(8'd136, d); check("R5 high idle", d, 32'h0);
    pins[24] = 1'b1; tick(5);
    rd(8'd136, d); check("R5 high pending", d, 32'h01);
    wr(8'd132, 32'h01); tick(1);
    rd(8'd136, d); check("R5 reasserts after ack", d, 32'h01);
    pins[24] = 1'b0; tick(5);
    rd(8'd136, d); check("R5 follows low", d, 32'h0);
    wr(8'd120, 32'd2); tick(2);
    rd(8'd136, d); check("R5 low-level pending", d, 32'h01);
    pins[24] = 1'b1; tick(5);
    rd(8'd136, d); check("R5 low-level clears", d, 32'h0);
    pins[24] = 1'b0;
  endtask

  task automatic t_set_off;
    logic [31:0] d;
    arm(32'h0, 32'd3 << 3, 32'h02);
    rd(8'd136, d); check("R6 set forces", d, 32'h02);
    wr(8'd120, 32'd4 << 3); tick(1);
    rd(8'd136, d); check("R6 code 4 off", d, 32'h0);
    // latch an edge on slot 1 (pin 1), then turn it off
    wr(8'd120, 32'd5 << 3); tick(1);
    pins[1] = 1'b1; tick(5);
    rd(8'd136, d); check("R6 edge before off", d, 32'h02);
    wr(8'd120, 32'h0); tick(1);
    rd(8'd136, d); check("R6 off discards", d, 32'h0);
    check("R9 irq idle", {31'b0, irq}, 32'h0);
    pins[1] = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset;
    t_regs;
    t_rise;
    t_fall;
    t_both;
    t_level;
    t_set_off;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule